// File: doc/BRIEF.md
# Flag-Setting Register ALU

This block is the arithmetic and logic unit for a register-to-register data-processing group. Each cycle it takes a 4-bit operation code, a destination operand `a`, a source operand `b`, and the incoming carry and overflow flags. One clock edge later it presents the result, a write-enable for the destination register, and new negative, zero, carry and overflow flags. The decode stage holds the register values and the flag state and feeds them in. It writes back `result` when `writeEn` is high and loads the four flag outputs into its flag register.

Three of the operations are compare-only and never write a register. Two are arithmetic with carry-in. There are also negate, bit-clear, invert and a single-cycle low-word multiply. The four shift and rotate codes are carried out by an external shifter. For those codes this block only signals the handoff and holds the carry and overflow flags.

Top module: `flag_alu`

## Requirements
- R1: The 4-bit code selects the operation: 0 AND, 1 EOR, 2 shift left, 3 logical shift right, 4 arithmetic shift right, 5 ADC, 6 SBC, 7 rotate right, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN.
- R2: AND, EOR and ORR give the bitwise function of `a` and `b`. BIC gives `a & ~b` and MVN gives `~b`. Each of these asserts `writeEn`.
- R3: TST (a & b), CMP (a − b) and CMN (a + b) drive `writeEn` low. They still present the computed value on `result` and set flags from it.
- R4: ADC computes a + b + cIn, and CMN computes a + b. The carry flag is bit WIDTH of the unsigned sum. The overflow flag is set when the exact signed sum falls outside the WIDTH-bit signed range.
- R5: A subtraction is formed as a + ~b + k. CMP uses k = 1, SBC uses k = cIn, and NEG uses 0 + ~b + 1. The carry flag is the carry out of that sum, so 1 means no borrow. The overflow flag is set when the exact signed difference falls outside the signed range.
- R6: For every code, `nOut` is the top bit of the value on `result` and `zOut` is 1 exactly when that value is zero.
- R7: AND, EOR, ORR, BIC, MVN, TST and MUL copy `cIn` to `cOut` and `vIn` to `vOut`.
- R8: MUL writes the low WIDTH bits of the unsigned product a × b.
- R9: For codes 2, 3, 4 and 7, `shiftOp` is 1, `writeEn` is 0, `result` equals `a`, and the carry and overflow flags are copied from the inputs. For every other code `shiftOp` is 0.
- R10: All outputs are registered. They update on the rising edge after the inputs are applied and are all zero while the synchronous active-high `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| a | input | WIDTH | Destination operand |
| b | input | WIDTH | Source operand |
| cIn | input | 1 | Current carry flag |
| vIn | input | 1 | Current overflow flag |
| result | output | WIDTH | Computed value (registered) |
| writeEn | output | 1 | Write the destination register |
| shiftOp | output | 1 | Code belongs to the external shifter |
| nOut | output | 1 | New negative flag |
| zOut | output | 1 | New zero flag |
| cOut | output | 1 | New carry flag |
| vOut | output | 1 | New overflow flag |

## Verification
All seven outputs come from one register stage, so each result is due at the first rising edge after its operands are applied and then holds until the next edge. The bench drives each vector on a falling edge and compares on the following falling edge, half a period after the edge that loaded it. It also confirms once that the outputs have not yet moved shortly after a new vector is driven. A 4-bit instance is swept over every code, operand pair and incoming flag pair, and a 32-bit instance covers directed multiply and overflow cases.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SHL = 4'd2,  OP_SHR = 4'd3,
    OP_SAR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROT = 4'd7,
    OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [2:0] {
    LG_AND   = 3'd0,
    LG_EOR   = 3'd1,
    LG_ORR   = 3'd2,
    LG_BIC   = 3'd3,
    LG_NOTB  = 3'd4,
    LG_PASSA = 3'd5
  } logicSel_e;

  typedef enum logic [1:0] {
    VS_ADDER = 2'd0,
    VS_LOGIC = 2'd1,
    VS_MUL   = 2'd2
  } valueSel_e;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic      zeroA;
    logic      invB;
    carrySel_e carrySel;
    logicSel_e logicSel;
    valueSel_e valueSel;
    logic      setCV;
    logic      writeEn;
    logic      shiftOp;
  } aluCtrl_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0] op,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{zeroA: 1'b0, invB: 1'b0, carrySel: CIN_ZERO, logicSel: LG_AND,
             valueSel: VS_LOGIC, setCV: 1'b0, writeEn: 1'b1, shiftOp: 1'b0};
    unique case (aluOp_e'(op))
      OP_AND: ctrl.logicSel = LG_AND;
      OP_EOR: ctrl.logicSel = LG_EOR;
      OP_ORR: ctrl.logicSel = LG_ORR;
      OP_BIC: ctrl.logicSel = LG_BIC;
      OP_MVN: ctrl.logicSel = LG_NOTB;
      OP_TST: begin
        ctrl.logicSel = LG_AND;
        ctrl.writeEn  = 1'b0;
      end
      OP_SHL, OP_SHR, OP_SAR, OP_ROT: begin
        ctrl.logicSel = LG_PASSA;
        ctrl.writeEn  = 1'b0;
        ctrl.shiftOp  = 1'b1;
      end
      OP_MUL: ctrl.valueSel = VS_MUL;
      OP_ADC: begin
        ctrl.valueSel = VS_ADDER;
        ctrl.carrySel = CIN_FLAG;
        ctrl.setCV    = 1'b1;
      end
      OP_CMN: begin
        ctrl.valueSel = VS_ADDER;
        ctrl.setCV    = 1'b1;
        ctrl.writeEn  = 1'b0;
      end
      OP_SBC: begin
        ctrl.valueSel = VS_ADDER;
        ctrl.invB     = 1'b1;
        ctrl.carrySel = CIN_FLAG;
        ctrl.setCV    = 1'b1;
      end
      OP_CMP: begin
        ctrl.valueSel = VS_ADDER;
        ctrl.invB     = 1'b1;
        ctrl.carrySel = CIN_ONE;
        ctrl.setCV    = 1'b1;
        ctrl.writeEn  = 1'b0;
      end
      OP_NEG: begin
        ctrl.valueSel = VS_ADDER;
        ctrl.zeroA    = 1'b1;
        ctrl.invB     = 1'b1;
        ctrl.carrySel = CIN_ONE;
        ctrl.setCV    = 1'b1;
      end
      default: ctrl.writeEn = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cIn,
  input  logic             vIn,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic             shiftOp,
  output logic             nOut,
  output logic             zOut,
  output logic             cOut,
  output logic             vOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opA, opB;
  logic             carryIn;
  logic [WIDTH:0]   sum;
  logic             addCarry, addOvf;
  logic [WIDTH-1:0] logicVal, mulVal, value;
  logic [2*WIDTH-1:0] product;

  // Shared adder for add, subtract and negate
  assign opA = ctrl.zeroA ? '0 : a;
  assign opB = ctrl.invB ? ~b : b;

  always_comb begin
    unique case (ctrl.carrySel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = cIn;
      default:  carryIn = 1'b0;
    endcase
  end

  assign sum      = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign addCarry = sum[WIDTH];
  assign addOvf   = (opA[MSB] == opB[MSB]) && (sum[MSB] != opA[MSB]);

  always_comb begin
    unique case (ctrl.logicSel)
      LG_EOR:   logicVal = a ^ b;
      LG_ORR:   logicVal = a | b;
      LG_BIC:   logicVal = a & ~b;
      LG_NOTB:  logicVal = ~b;
      LG_PASSA: logicVal = a;
      default:  logicVal = a & b;
    endcase
  end

  assign product = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
  assign mulVal  = product[WIDTH-1:0];

  always_comb begin
    unique case (ctrl.valueSel)
      VS_ADDER: value = sum[WIDTH-1:0];
      VS_MUL:   value = mulVal;
      default:  value = logicVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      writeEn <= 1'b0;
      shiftOp <= 1'b0;
      nOut    <= 1'b0;
      zOut    <= 1'b0;
      cOut    <= 1'b0;
      vOut    <= 1'b0;
    end else begin
      result  <= value;
      writeEn <= ctrl.writeEn;
      shiftOp <= ctrl.shiftOp;
      nOut    <= value[MSB];
      zOut    <= ~|value;
      cOut    <= ctrl.setCV ? addCarry : cIn;
      vOut    <= ctrl.setCV ? addOvf : vIn;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cIn,
  input  logic             vIn,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic             shiftOp,
  output logic             nOut,
  output logic             zOut,
  output logic             cOut,
  output logic             vOut
);

  aluCtrl_t ctrl;

  flag_alu_ctrl u_ctrl (
    .op   (op),
    .ctrl (ctrl)
  );

  flag_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .a       (a),
    .b       (b),
    .cIn     (cIn),
    .vIn     (vIn),
    .result  (result),
    .writeEn (writeEn),
    .shiftOp (shiftOp),
    .nOut    (nOut),
    .zOut    (zOut),
    .cOut    (cOut),
    .vOut    (vOut)
  );

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cIn,
  input logic             vIn,
  input logic [WIDTH-1:0] result,
  input logic             writeEn,
  input logic             shiftOp,
  input logic             nOut,
  input logic             zOut,
  input logic             cOut,
  input logic             vOut
);

  logic isCompare, isShift, keepsCV;
  assign isCompare = (op == 4'd8) || (op == 4'd10) || (op == 4'd11);
  assign isShift   = (op == 4'd2) || (op == 4'd3) || (op == 4'd4) || (op == 4'd7);
  assign keepsCV   = (op == 4'd0) || (op == 4'd1) || (op == 4'd8) || (op == 4'd12) ||
                     (op == 4'd13) || (op == 4'd14) || (op == 4'd15);

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    isCompare |=> !writeEn); // R3

  AST_SHIFT_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    isShift |=> (shiftOp && !writeEn && result == $past(a))); // R9

  AST_SHIFT_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !isShift |=> !shiftOp); // R9

  AST_CV_HOLD: assert property (@(posedge clk) disable iff (rst)
    keepsCV |=> (cOut == $past(cIn) && vOut == $past(vIn))); // R7

  AST_MVN_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd15) |=> (result == ~$past(b) && writeEn)); // R2

  AST_NEG_OF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd9 && b == '0) |=> (cOut && zOut && !vOut && !nOut)); // R5

endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .cIn(cIn), .vIn(vIn),
  .result(result), .writeEn(writeEn), .shiftOp(shiftOp),
  .nOut(nOut), .zOut(zOut), .cOut(cOut), .vOut(vOut)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

  localparam int NW = 4;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [3:0]    nOp = '0;
  logic [NW-1:0] nA = '0, nB = '0;
  logic          nC = 1'b0, nV = 1'b0;
  logic [NW-1:0] nRes;
  logic          nWe, nSh, nN, nZ, nCo, nVo;

  logic [3:0]    wOp = '0;
  logic [WW-1:0] wA = '0, wB = '0;
  logic          wC = 1'b0, wV = 1'b0;
  logic [WW-1:0] wRes;
  logic          wWe, wSh, wN, wZ, wCo, wVo;

  flag_alu #(.WIDTH(NW)) u_dut (
    .clk(clk), .rst(rst), .op(nOp), .a(nA), .b(nB), .cIn(nC), .vIn(nV),
    .result(nRes), .writeEn(nWe), .shiftOp(nSh),
    .nOut(nN), .zOut(nZ), .cOut(nCo), .vOut(nVo)
  );

  flag_alu #(.WIDTH(WW)) u_wide (
    .clk(clk), .rst(rst), .op(wOp), .a(wA), .b(wB), .cIn(wC), .vIn(wV),
    .result(wRes), .writeEn(wWe), .shiftOp(wSh),
    .nOut(wN), .zOut(wZ), .cOut(wCo), .vOut(wVo)
  );

  // Reference model, from the requirements. Packing: {we, sh, n, z, c, v, value[31:0]}
  // R1: code values as listed in the brief
  function automatic logic [37:0] model(input int w, input logic [3:0] op,
                                        input longint a, input longint b,
                                        input logic c, input logic v);
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint ua = a & mask;
    longint ub = b & mask;
    longint sa = (ua ^ half) - half;
    longint sb = (ub ^ half) - half;
    longint ci = c ? 1 : 0;
    longint full = 0, sfull = 0, val = 0;
    logic we = 1'b1, sh = 1'b0, arith = 1'b0, co = c, vo = v;
    case (op)
      4'd0:  val = ua & ub;
      4'd1:  val = ua ^ ub;
      4'd12: val = ua | ub;
      4'd14: val = ua & ~ub & mask;
      4'd15: val = ~ub & mask;
      4'd8:  begin val = ua & ub; we = 1'b0; end
      4'd13: val = (ua * ub) & mask;
      4'd2, 4'd3, 4'd4, 4'd7: begin val = ua; we = 1'b0; sh = 1'b1; end
      4'd5:  begin arith = 1'b1; full = ua + ub + ci;            sfull = sa + sb + ci; end
      4'd6:  begin arith = 1'b1; full = ua + (mask - ub) + ci;   sfull = sa - sb - (1 - ci); end
      4'd9:  begin arith = 1'b1; full = (mask - ub) + 1;         sfull = -sb; end
      4'd10: begin arith = 1'b1; full = ua + (mask - ub) + 1;    sfull = sa - sb; we = 1'b0; end
      default: begin arith = 1'b1; full = ua + ub;               sfull = sa + sb; we = 1'b0; end
    endcase
    if (arith) begin
      val = full & mask;
      co  = ((full >> w) & 1) != 0;
      vo  = (sfull > half - 1) || (sfull < -half);
    end
    return {we, sh, ((val >> (w - 1)) & 1) != 0, val == 0, co, vo, 32'(val)};
  endfunction

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd12, 4'd14, 4'd15: return "R2";
      4'd8, 4'd10:                      return "R3";
      4'd5, 4'd11:                      return "R4";
      4'd6, 4'd9:                       return "R5";
      4'd13:                            return "R8";
      default:                          return "R9";
    endcase
  endfunction

  function automatic string cvTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd8, 4'd12, 4'd13, 4'd14, 4'd15: return "R7";
      4'd10:                                         return "R5";
      default:                                       return opTag(op);
    endcase
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input logic [3:0] op, input logic [37:0] exp,
                            input logic [37:0] got);
    checkVal(opTag(op), $sformatf("value op=%0d", op), longint'(got[31:0]), longint'(exp[31:0]));
    checkVal((op == 4'd8 || op == 4'd10 || op == 4'd11) ? "R3" : opTag(op),
             $sformatf("writeEn op=%0d", op), longint'(got[37]), longint'(exp[37]));
    checkVal("R9", $sformatf("shiftOp op=%0d", op), longint'(got[36]), longint'(exp[36]));
    checkVal("R6", $sformatf("N,Z op=%0d", op), longint'(got[35:34]), longint'(exp[35:34]));
    checkVal(cvTag(op), $sformatf("C,V op=%0d", op), longint'(got[33:32]), longint'(exp[33:32]));
  endtask

  task automatic runNarrow(input logic [3:0] op, input int a, input int b,
                           input logic c, input logic v);
    @(negedge clk);
    nOp = op; nA = NW'(a); nB = NW'(b); nC = c; nV = v;
    @(negedge clk);
    compareAll(op, model(NW, op, longint'(a), longint'(b), c, v),
               {nWe, nSh, nN, nZ, nCo, nVo, 32'(nRes)});
  endtask

  task automatic runWide(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic c, input logic v);
    @(negedge clk);
    wOp = op; wA = a; wB = b; wC = c; wV = v;
    @(negedge clk);
    compareAll(op, model(WW, op, longint'(a), longint'(b), c, v),
               {wWe, wSh, wN, wZ, wCo, wVo, wRes});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state, all outputs zero
    checkVal("R10", "reset narrow", longint'({nRes, nWe, nSh, nN, nZ, nCo, nVo}), 0);
    checkVal("R10", "reset wide", longint'({wWe, wSh, wN, wZ, wCo, wVo}), 0);
    checkVal("R10", "reset wide result", longint'(wRes), 0);
    rst = 1'b0;
    // R10: one-edge latency, outputs unchanged before the edge
    nOp = 4'd15; nB = '0;
    #2;
    checkVal("R10", "before edge", longint'(nRes), 0);
    @(negedge clk);
    checkVal("R10", "after edge", longint'(nRes), longint'(4'hF));

    // Exhaustive sweep of the narrow instance (R1..R9)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int f = 0; f < 4; f++)
            runNarrow(4'(op), a, b, f[1], f[0]);

    // Wide directed corners
    runWide(4'd13, 32'h0001_0000, 32'h0001_0003, 1'b1, 1'b0);   // R8 high bits dropped
    runWide(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);   // R8, R7
    runWide(4'd5,  32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);   // R4 overflow via carry-in
    runWide(4'd5,  32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1);   // R4 carry out, zero
    runWide(4'd11, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);   // R4, R3
    runWide(4'd10, 32'h0000_0005, 32'h0000_0007, 1'b1, 1'b0);   // R5 borrow
    runWide(4'd6,  32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0);   // R5 overflow via borrow-in
    runWide(4'd9,  32'h1234_5678, 32'h8000_0000, 1'b0, 1'b0);   // R5 negate of minimum
    runWide(4'd9,  32'h1234_5678, 32'h0000_0000, 1'b0, 1'b1);   // R5 negate of zero
    runWide(4'd14, 32'hF0F0_FFFF, 32'h00FF_0F0F, 1'b1, 1'b1);   // R2, R7
    runWide(4'd7,  32'hDEAD_BEEF, 32'h0000_0004, 1'b1, 1'b0);   // R9

    rst = 1'b1;
    @(negedge clk);
    checkVal("R10", "reset after run", longint'({nRes, nWe, nSh, nN, nZ, nCo, nVo}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule